// File: doc/BRIEF.md
# SEC-DED Codeword Decoder with Odd Overall Parity

This block checks and repairs a 39-bit protected word read back from a memory. The word carries 32 data bits and 7 check bits. Six of the check bits form a Hamming code over the data. The seventh check bit is chosen so that the whole word holds an odd number of ones. The decoder recomputes both checks and packs them into an 8-bit syndrome. From that syndrome it sorts each word into one of three classes: clean, single-bit error that can be repaired, or an error that cannot be corrected. For a repairable data-bit error it inverts the failing bit before returning the data.

The decoder has one register stage. A word presented with `inValid` high is decoded and appears on the outputs on the next clock edge, with `outValid` high. The outputs keep their values while no new word arrives. The syndrome encoding is unusual: the value 0x01 means a clean word. The value 0x00 does not mean a clean word. It points at check bit 0, which is the overall-parity bit.

Top module: `secded_odd_decoder`

## Requirements
- R1: A word sampled with `inValid` high produces its results and `outValid` high after exactly one rising edge. After reset, `outValid`, `outNoErr`, `outCorrected` and `outUncorrectable` are 0, `outData` is 0 and `outSyndrome` is 0x01.
- R2: Codeword bits [31:0] hold data bits 0..31 and bits [38:32] hold check bits 0..6. A valid word has an odd number of ones. `outSyndrome[0]` is 1 exactly when the XOR of all 39 received bits is 1.
- R3: `outSyndrome[6:1]` is the XOR of the position codes of all set bits. Check bit 0 has code 0. Check bit k (k = 1..6) has code 1<<(k-1). Data bit i has the i-th smallest 6-bit value with at least two ones, so bit 0 → 3 and bit 31 → 38. `outSyndrome[7]` is always 0.
- R4: A valid codeword gives syndrome 0x01, `outNoErr` high, and the data unchanged.
- R5: A single flipped check bit is reported as corrected, with the data unchanged. A flip of check bit 0 gives syndrome 0x00. A flip of check bit k gives 1<<k, so check 1 → 0x02 and check 2 → 0x04.
- R6: A single flipped data bit i gives syndrome {0, code(i), 0}, `outCorrected` high, and the data with bit i inverted back to its written value.
- R7: An even number of flips with a non-zero position field (`outSyndrome[0]` = 1) is non-correctable, and the received data passes through unchanged.
- R8: A failing parity check whose position field is neither 0, nor a single one, nor a data code is non-correctable, and the received data passes through unchanged.
- R9: For every decoded word, exactly one of `outNoErr`, `outCorrected` and `outUncorrectable` is high.
- R10: While `inValid` is low, all data, syndrome and flag outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Marks `inCode` as a word to decode |
| inCode | input | 39 | Received codeword: data in [31:0], check bits in [38:32] |
| outValid | output | 1 | Results below belong to the word taken on the previous edge |
| outData | output | 32 | Corrected data, or the raw data for an error that cannot be corrected |
| outSyndrome | output | 8 | Position field in [6:1], overall-parity result in [0], [7] is zero |
| outNoErr | output | 1 | The word was clean |
| outCorrected | output | 1 | A single-bit error was repaired |
| outUncorrectable | output | 1 | A multi-bit error was detected |

## Verification
Clean words with all-zero, all-one, alternating and pseudo-random data show that the parity bit is odd and that no data bit is corrected by mistake. Each of the 39 single-bit flips is applied to two data values. These separate the check-bit cases (syndromes 0x00, 0x02, 0x04 and so on, with the data untouched) from the data-bit cases that are inverted back. Every pair of flips on one word shows that an even error weight always lands in the non-correctable class. A three-check-bit flip with an unused position code shows that an odd weight is not blindly corrected. Idle cycles between words show that the outputs hold.

// File: rtl/secded_pkg.sv
package secded_pkg;
  localparam int DATA_W = 32;
  localparam int HAM_W  = 6;
  localparam int CHK_W  = HAM_W + 1;
  localparam int CW_W   = DATA_W + CHK_W;
  localparam int SYN_W  = HAM_W + 2;

  typedef enum logic [1:0] {
    CLS_CLEAN,
    CLS_CHECK,
    CLS_DATA,
    CLS_MULTI
  } errClass_t;

  typedef struct packed {
    logic capture;
  } ctlStrobe_t;

  // i-th smallest HAM_W-bit value with two or more ones
  function automatic logic [HAM_W-1:0] dataCode(input int idx);
    int seen;
    logic [HAM_W-1:0] result;
    seen = 0;
    result = '0;
    for (int v = 3; v < (1 << HAM_W); v++) begin
      if ($countones(v[HAM_W-1:0]) >= 2) begin
        if (seen == idx) result = v[HAM_W-1:0];
        seen++;
      end
    end
    return result;
  endfunction

  function automatic logic [DATA_W*HAM_W-1:0] buildCodeTable();
    logic [DATA_W*HAM_W-1:0] tbl;
    for (int i = 0; i < DATA_W; i++) tbl[i*HAM_W +: HAM_W] = dataCode(i);
    return tbl;
  endfunction

  localparam logic [DATA_W*HAM_W-1:0] CODE_TABLE = buildCodeTable();
endpackage

// File: rtl/secded_control.sv
module secded_control
  import secded_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  output ctlStrobe_t ctl,
  output logic       outValid
);
  always_comb ctl.capture = inValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= ctl.capture;
  end

  // R1: one-cycle latency of the valid marker
  assert_valid_rise_R1: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  assert_valid_idle_R1: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
endmodule

// File: rtl/secded_datapath.sv
module secded_datapath
  import secded_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        ctl,
  input  logic [CW_W-1:0]   inCode,
  output logic [DATA_W-1:0] outData,
  output logic [SYN_W-1:0]  outSyndrome,
  output logic              outNoErr,
  output logic              outCorrected,
  output logic              outUncorrectable
);
  logic [DATA_W-1:0] dataIn;
  logic [CHK_W-1:0]  chkIn;
  logic [HAM_W-1:0]  hamSyn;
  logic              parityOk;
  logic [DATA_W-1:0] dataHit;
  logic              posOneHot;
  errClass_t         cls;
  logic [DATA_W-1:0] flipMask;
  logic [SYN_W-1:0]  synNext;

  assign dataIn = inCode[DATA_W-1:0];
  assign chkIn  = inCode[CW_W-1:DATA_W];

  // Overall odd parity: 1 means the word still holds an odd count of ones
  assign parityOk = ^inCode;

  always_comb begin
    hamSyn = chkIn[CHK_W-1:1];
    for (int i = 0; i < DATA_W; i++) begin
      if (dataIn[i]) hamSyn = hamSyn ^ CODE_TABLE[i*HAM_W +: HAM_W];
    end
  end

  genvar g;
  generate
    for (g = 0; g < DATA_W; g++) begin : gen_match
      assign dataHit[g] = (hamSyn == CODE_TABLE[g*HAM_W +: HAM_W]);
    end
  endgenerate

  assign posOneHot = (hamSyn != '0) && ((hamSyn & (hamSyn - 1'b1)) == '0);

  always_comb begin
    if (parityOk)                       cls = (hamSyn == '0) ? CLS_CLEAN : CLS_MULTI;
    else if (hamSyn == '0 || posOneHot) cls = CLS_CHECK;
    else if (|dataHit)                  cls = CLS_DATA;
    else                                cls = CLS_MULTI;
  end

  assign flipMask = (cls == CLS_DATA) ? dataHit : '0;
  assign synNext  = {{(SYN_W-HAM_W-1){1'b0}}, hamSyn, parityOk};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outData          <= '0;
      outSyndrome      <= {{(SYN_W-1){1'b0}}, 1'b1};
      outNoErr         <= 1'b0;
      outCorrected     <= 1'b0;
      outUncorrectable <= 1'b0;
    end else if (ctl.capture) begin
      outData          <= dataIn ^ flipMask;
      outSyndrome      <= synNext;
      outNoErr         <= (cls == CLS_CLEAN);
      outCorrected     <= (cls == CLS_CHECK) || (cls == CLS_DATA);
      outUncorrectable <= (cls == CLS_MULTI);
    end
  end

  assert_one_class_R9: assert property (@(posedge clk) disable iff (!rstN)
    ctl.capture |=> $onehot({outNoErr, outCorrected, outUncorrectable}));
  assert_clean_syndrome_R4: assert property (@(posedge clk) disable iff (!rstN)
    ctl.capture |=> (outNoErr == (outSyndrome == 8'h01)));
  assert_clean_data_R4: assert property (@(posedge clk) disable iff (!rstN)
    ctl.capture |=> (!outNoErr || outData == $past(inCode[DATA_W-1:0])));
  assert_uncorr_passthru_R8: assert property (@(posedge clk) disable iff (!rstN)
    ctl.capture |=> (!outUncorrectable || outData == $past(inCode[DATA_W-1:0])));
  assert_corrected_parity_R6: assert property (@(posedge clk) disable iff (!rstN)
    ctl.capture |=> (!outCorrected || !outSyndrome[0]));
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.capture |=> ($stable(outData) && $stable(outSyndrome) && $stable(outNoErr)
                      && $stable(outCorrected) && $stable(outUncorrectable)));
endmodule

// File: rtl/secded_odd_decoder.sv
module secded_odd_decoder
  import secded_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [CW_W-1:0]   inCode,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic [SYN_W-1:0]  outSyndrome,
  output logic              outNoErr,
  output logic              outCorrected,
  output logic              outUncorrectable
);
  ctlStrobe_t ctl;

  secded_control u_control (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .ctl      (ctl),
    .outValid (outValid)
  );

  secded_datapath u_datapath (
    .clk              (clk),
    .rstN             (rstN),
    .ctl              (ctl),
    .inCode           (inCode),
    .outData          (outData),
    .outSyndrome      (outSyndrome),
    .outNoErr         (outNoErr),
    .outCorrected     (outCorrected),
    .outUncorrectable (outUncorrectable)
  );
endmodule

// File: tb/secded_odd_decoder_tb.sv
module secded_odd_decoder_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [38:0] inCode = '0;
  logic        outValid;
  logic [31:0] outData;
  logic [7:0]  outSyndrome;
  logic        outNoErr, outCorrected, outUncorrectable;

  int vectors = 0;
  int errors  = 0;
  int pushed  = 0;
  int popped  = 0;
  bit done    = 1'b0;

  typedef struct {
    logic [31:0] data;
    logic [7:0]  syn;
    logic [2:0]  flags;   // {noErr, corrected, uncorrectable}
    string       req;
  } expItem_t;

  expItem_t expQ[$];
  expItem_t lastExp;

  always #2 clk = ~clk;

  secded_odd_decoder u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inCode(inCode),
    .outValid(outValid), .outData(outData), .outSyndrome(outSyndrome),
    .outNoErr(outNoErr), .outCorrected(outCorrected),
    .outUncorrectable(outUncorrectable)
  );

  // Position code per R3: i-th 6-bit value with at least two ones
  function automatic logic [5:0] posOfData(input int idx);
    int n = 0;
    for (int v = 3; v < 64; v++) begin
      if ($countones(v[5:0]) > 1) begin
        if (n == idx) return v[5:0];
        n++;
      end
    end
    return 6'd0;
  endfunction

  function automatic logic [5:0] posOfBit(input int b);
    if (b < 32)  return posOfData(b);
    if (b == 32) return 6'd0;
    return 6'(1 << (b - 33));
  endfunction

  function automatic logic [38:0] encode(input logic [31:0] d);
    logic [6:0] c = '0;
    for (int i = 0; i < 32; i++)
      for (int k = 1; k < 7; k++)
        if (d[i] && posOfData(i)[k-1]) c[k] = ~c[k];
    c[0] = ~(^d ^ ^c[6:1]);
    return {c, d};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Driver: build word, flip bits, predict from requirements, push, drive
  task automatic sendWord(input logic [31:0] d, input logic [38:0] flips);
    expItem_t e;
    logic [5:0] pos = '0;
    int nFlips = $countones(flips);
    bit parOk = (nFlips % 2) == 0;
    int dataIdx = -1;
    for (int b = 0; b < 39; b++) if (flips[b]) pos ^= posOfBit(b);
    e.syn = {1'b0, pos, parOk};
    e.data = d ^ flips[31:0];
    if (parOk && pos == 0) begin
      e.flags = 3'b100; e.req = "R4"; e.data = d;
    end else if (parOk) begin
      e.flags = 3'b001; e.req = "R7";
    end else if (pos == 0 || $onehot(pos)) begin
      e.flags = 3'b010; e.req = "R5";
    end else begin
      for (int i = 0; i < 32; i++) if (posOfData(i) == pos) dataIdx = i;
      if (dataIdx >= 0) begin
        e.flags = 3'b010; e.req = "R6";
        e.data[dataIdx] = ~e.data[dataIdx];
      end else begin
        e.flags = 3'b001; e.req = "R8";
      end
    end
    expQ.push_back(e);
    pushed++;
    @(negedge clk);
    inCode  = encode(d) ^ flips;
    inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  // Monitor: pops one expected item for every valid output
  always @(negedge clk) begin
    #1;
    if (rstN && outValid) begin
      expItem_t e;
      if (expQ.size() == 0) begin
        check(1'b0, "R1", "unexpected outValid", 64'(outValid), 64'd0);
      end else begin
        e = expQ.pop_front();
        popped++;
        lastExp = e;
        check(outSyndrome[0] == e.syn[0], "R2", "parity bit", 64'(outSyndrome[0]), 64'(e.syn[0]));
        check(outSyndrome == e.syn, {e.req, " R3"}, "syndrome", 64'(outSyndrome), 64'(e.syn));
        check(outData == e.data, e.req, "data", 64'(outData), 64'(e.data));
        check({outNoErr, outCorrected, outUncorrectable} == e.flags, {e.req, " R9"}, "flags",
              64'({outNoErr, outCorrected, outUncorrectable}), 64'(e.flags));
      end
    end
  end

  initial begin
    logic [31:0] lfsr = 32'h1234_5678;
    repeat (3) @(negedge clk);
    check(outValid == 1'b0, "R1", "reset outValid", 64'(outValid), 64'd0);
    check({outNoErr, outCorrected, outUncorrectable} == 3'b000, "R1", "reset flags",
          64'({outNoErr, outCorrected, outUncorrectable}), 64'd0);
    check(outSyndrome == 8'h01 && outData == 0, "R1", "reset syndrome/data",
          {24'd0, outSyndrome, outData}, {24'd0, 8'h01, 32'd0});
    rstN = 1'b1;
    @(negedge clk);

    // R4: clean words, several data patterns
    sendWord(32'h0000_0000, '0);
    sendWord(32'hFFFF_FFFF, '0);
    sendWord(32'hA5A5_5A5A, '0);
    for (int n = 0; n < 8; n++) begin
      lfsr = lfsr * 32'd1664525 + 32'd1013904223;
      sendWord(lfsr, '0);
    end

    // R5, R6: every single-bit flip on two data values
    for (int b = 0; b < 39; b++) sendWord(32'hDEAD_BEEF, 39'(1) << b);
    for (int b = 0; b < 39; b++) sendWord(32'h0000_0000, 39'(1) << b);

    // R7: every pair of flips on one word
    for (int a = 0; a < 39; a++)
      for (int b = a + 1; b < 39; b++)
        sendWord(32'h1357_9BDF, (39'(1) << a) | (39'(1) << b));

    // R8: triple flip of check bits 1,5,6 gives unused code 49
    sendWord(32'hCAFE_F00D, (39'(1) << 33) | (39'(1) << 37) | (39'(1) << 38));

    // R10: hold while idle, with the input changing underneath
    inCode = 39'h55_5555_5555;
    repeat (5) @(negedge clk);
    #1;
    check(outData == lastExp.data && outSyndrome == lastExp.syn, "R10", "hold data/syndrome",
          {24'd0, outSyndrome, outData}, {24'd0, lastExp.syn, lastExp.data});
    check({outNoErr, outCorrected, outUncorrectable} == lastExp.flags, "R10", "hold flags",
          64'({outNoErr, outCorrected, outUncorrectable}), 64'(lastExp.flags));
    check(pushed == popped, "R1", "outputs per input", 64'(popped), 64'(pushed));
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
    if (!done) check(1'b0, "R1", "watchdog expired", 64'd0, 64'd1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule